// File: doc/BRIEF.md
# Row/Column Command Spacing Checker

This block watches the command streams that a memory controller sends to a group of memory devices. Row commands open a bank (activate) or close one (precharge). Column commands read, write, or do nothing. Each command carries a device ID and a bank number. The controller also supplies a free-running cycle count, which the block uses as the timestamp of every command.

For each device, the block keeps one record: the kind, bank and timestamp of the most recent row command. A new row command or column command is classified against that record.
- A pair that is closer together than its programmed minimum raises a spacing violation.
- A data access to a bank next to the recorded bank cannot be legal, so it is flagged as illegal whatever the gap.

Both results come out one clock later, together with a 4-bit code that names the rule that fired. The two minimum intervals are held in registers that the controller can load. The block is meant to sit beside the controller as a protocol monitor, both in simulation and in silicon.

Top module: `rc_spacing_chk`

## Requirements
- R1: After reset, `viol`, `illegal` and `rule_code` are 0 and no device has a record. A command to a device that has no record never flags.
- R2: A precharge (`row_op`=1) to a device whose record is also a precharge, with a gap below the precharge-to-precharge limit, raises `viol` with `rule_code`=1. This holds for any bank of that device. A gap equal to or above the limit raises nothing. The gap is (`now_cyc` at the new command − stored timestamp) modulo 2^TW.
- R3: Precharges to two different devices never restrict each other.
- R4: A read or write (`col_op` nonzero: 1 read, 2 write, 3 retire) to the same bank as an activate record (`row_op`=0) on that device raises `viol` with `rule_code`=2 when the gap is below the activate-to-access limit. Otherwise it raises nothing.
- R5: A read or write to bank B−1 or B+1 of a device whose record names bank B raises `illegal` regardless of the gap. `rule_code` is 3 when the record is an activate and 4 when it is a precharge. Banks do not wrap, so bank 0 and bank NBANK−1 are not neighbours.
- R6: A column no-op (`col_op`=0), or a read or write to a bank that is neither B nor B±1, raises nothing.
- R7: A column command in the same cycle as a row command to the same device is classed as a column-before-row pair. It is compared only with the record that existed before that row command.
- R8: `cfg_load` copies `cfg_tpp` and `cfg_trcd` into the limit registers, and commands from the next cycle on use the new values. Reset restores the parameter defaults.
- R9: Results are registered and appear one cycle after the command. If both streams flag in the same cycle, the column result wins. `viol` and `illegal` are never high together, and `rule_code` is 0 when neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load both limit registers |
| cfg_tpp | input | LW | Precharge-to-precharge limit, in cycles |
| cfg_trcd | input | LW | Activate-to-access limit, in cycles |
| now_cyc | input | TW | Free-running cycle count used as the timestamp |
| row_vld | input | 1 | Row command present |
| row_op | input | 1 | 0 activate, 1 precharge |
| row_dev | input | DW | Row command device |
| row_bank | input | BW | Row command bank |
| col_vld | input | 1 | Column command present |
| col_op | input | 2 | 0 no-op, 1 read, 2 write, 3 retire |
| col_dev | input | DW | Column command device |
| col_bank | input | BW | Column command bank |
| viol | output | 1 | Spacing violation strobe |
| illegal | output | 1 | Illegal access strobe |
| rule_code | output | 4 | Rule that fired (0 when neither strobe is high) |

## Verification
The bench runs precharge pairs whose gaps land one below and exactly at the limit. This separates a strict comparison from an inclusive one, and a same-device pair from a cross-device pair. Accesses after an activate are aimed at the same bank, at both neighbours, at the bank-0 edge against the top bank, and at a distant bank. This separates the timing rule from the illegal rule and checks the handling of bank edges. Commands to the same device in the same cycle show which record the column check uses. Colliding row and column faults show the priority between them, and reloaded limits show when new values take effect.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic {ROW_ACT = 1'b0, ROW_PRE = 1'b1} row_op_e;
  typedef enum logic [1:0] {COL_NOP = 2'd0, COL_RD = 2'd1, COL_WR = 2'd2, COL_RET = 2'd3} col_op_e;
  typedef enum logic [3:0] {
    RULE_NONE    = 4'd0,
    RULE_PP      = 4'd1,
    RULE_RCD     = 4'd2,
    RULE_ADJ_ACT = 4'd3,
    RULE_ADJ_PRE = 4'd4
  } rule_e;
endpackage

// File: rtl/rcc_dev_table.sv
module rcc_dev_table #(
  parameter int NDEV = 4,
  parameter int BW   = 4,
  parameter int TW   = 16,
  localparam int DW  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_dev,
  input  logic          wr_op,
  input  logic [BW-1:0] wr_bank,
  input  logic [TW-1:0] wr_ts,
  input  logic [DW-1:0] a_dev,
  output logic          a_hit,
  output logic          a_op,
  output logic [TW-1:0] a_ts,
  input  logic [DW-1:0] b_dev,
  output logic          b_hit,
  output logic          b_op,
  output logic [BW-1:0] b_bank,
  output logic [TW-1:0] b_ts
);
  logic [NDEV-1:0] live;
  logic            op_mem   [NDEV];
  logic [BW-1:0]   bank_mem [NDEV];
  logic [TW-1:0]   ts_mem   [NDEV];

  // only the presence bits are reset; the payload arrays carry no reset
  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (wr_en) live[wr_dev] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      op_mem[wr_dev]   <= wr_op;
      bank_mem[wr_dev] <= wr_bank;
      ts_mem[wr_dev]   <= wr_ts;
    end
  end

  assign a_hit  = live[a_dev];
  assign a_op   = op_mem[a_dev];
  assign a_ts   = ts_mem[a_dev];
  assign b_hit  = live[b_dev];
  assign b_op   = op_mem[b_dev];
  assign b_bank = bank_mem[b_dev];
  assign b_ts   = ts_mem[b_dev];
endmodule

// File: rtl/rcc_row_rule.sv
module rcc_row_rule #(
  parameter int TW = 16
) (
  input  logic          vld,
  input  logic          op,
  input  logic          hit,
  input  logic          rec_op,
  input  logic [TW-1:0] gap,
  input  logic [TW-1:0] limit,
  output logic          fire,
  output logic [3:0]    code
);
  import rcc_pkg::*;

  always_comb begin
    fire = vld && hit && (op == ROW_PRE) && (rec_op == ROW_PRE) && (gap < limit);
    code = fire ? RULE_PP : RULE_NONE;
  end
endmodule

// File: rtl/rcc_col_rule.sv
module rcc_col_rule #(
  parameter int BW = 4,
  parameter int TW = 16
) (
  input  logic          vld,
  input  logic [1:0]    op,
  input  logic [BW-1:0] bank,
  input  logic          hit,
  input  logic          rec_op,
  input  logic [BW-1:0] rec_bank,
  input  logic [TW-1:0] gap,
  input  logic [TW-1:0] limit,
  output logic          viol,
  output logic          bad,
  output logic [3:0]    code
);
  import rcc_pkg::*;

  logic          access, same, adj;
  logic [BW:0]   nb, rb;

  always_comb begin
    nb     = {1'b0, bank};
    rb     = {1'b0, rec_bank};
    access = vld && hit && (op != COL_NOP);
    same   = (bank == rec_bank);
    adj    = (nb == rb + 1'b1) || (nb + 1'b1 == rb);
    bad    = access && adj;
    viol   = access && same && (rec_op == ROW_ACT) && (gap < limit);
    if (bad)       code = (rec_op == ROW_ACT) ? RULE_ADJ_ACT : RULE_ADJ_PRE;
    else if (viol) code = RULE_RCD;
    else           code = RULE_NONE;
  end
endmodule

// File: rtl/rc_spacing_chk.sv
module rc_spacing_chk #(
  parameter int NDEV     = 4,
  parameter int NBANK    = 16,
  parameter int TW       = 16,
  parameter int LW       = 8,
  parameter int TPP_RST  = 8,
  parameter int TRCD_RST = 11,
  localparam int DW = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [LW-1:0] cfg_tpp,
  input  logic [LW-1:0] cfg_trcd,
  input  logic [TW-1:0] now_cyc,
  input  logic          row_vld,
  input  logic          row_op,
  input  logic [DW-1:0] row_dev,
  input  logic [BW-1:0] row_bank,
  input  logic          col_vld,
  input  logic [1:0]    col_op,
  input  logic [DW-1:0] col_dev,
  input  logic [BW-1:0] col_bank,
  output logic          viol,
  output logic          illegal,
  output logic [3:0]    rule_code
);
  import rcc_pkg::*;

  logic [LW-1:0] lim_pp, lim_rcd;
  logic          a_hit, a_op, b_hit, b_op;
  logic [TW-1:0] a_ts, b_ts, gap_row, gap_col;
  logic [BW-1:0] b_bank;
  logic          row_fire, col_viol, col_bad;
  logic [3:0]    row_code, col_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_pp  <= LW'(TPP_RST);
      lim_rcd <= LW'(TRCD_RST);
    end else if (cfg_load) begin
      lim_pp  <= cfg_tpp;
      lim_rcd <= cfg_trcd;
    end
  end

  rcc_dev_table #(.NDEV(NDEV), .BW(BW), .TW(TW)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(row_vld), .wr_dev(row_dev), .wr_op(row_op), .wr_bank(row_bank), .wr_ts(now_cyc),
    .a_dev(row_dev), .a_hit(a_hit), .a_op(a_op), .a_ts(a_ts),
    .b_dev(col_dev), .b_hit(b_hit), .b_op(b_op), .b_bank(b_bank), .b_ts(b_ts)
  );

  assign gap_row = now_cyc - a_ts;
  assign gap_col = now_cyc - b_ts;

  rcc_row_rule #(.TW(TW)) u_row (
    .vld(row_vld), .op(row_op), .hit(a_hit), .rec_op(a_op),
    .gap(gap_row), .limit(TW'(lim_pp)), .fire(row_fire), .code(row_code)
  );

  rcc_col_rule #(.BW(BW), .TW(TW)) u_col (
    .vld(col_vld), .op(col_op), .bank(col_bank), .hit(b_hit), .rec_op(b_op),
    .rec_bank(b_bank), .gap(gap_col), .limit(TW'(lim_rcd)),
    .viol(col_viol), .bad(col_bad), .code(col_code)
  );

  // column result takes priority over the row result
  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      illegal   <= 1'b0;
      rule_code <= RULE_NONE;
    end else if (col_bad) begin
      viol      <= 1'b0;
      illegal   <= 1'b1;
      rule_code <= col_code;
    end else if (col_viol) begin
      viol      <= 1'b1;
      illegal   <= 1'b0;
      rule_code <= col_code;
    end else if (row_fire) begin
      viol      <= 1'b1;
      illegal   <= 1'b0;
      rule_code <= row_code;
    end else begin
      viol      <= 1'b0;
      illegal   <= 1'b0;
      rule_code <= RULE_NONE;
    end
  end

  p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({viol, illegal}));
  p_code_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(viol || illegal) |-> rule_code == 4'd0);
  p_quiet_without_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    !row_vld && !col_vld |=> !viol && !illegal);
  p_illegal_from_access_r5: assert property (@(posedge clk) disable iff (rst)
    col_vld && col_op != 2'd0 && !row_vld && !b_hit |=> !illegal);
  p_pp_from_precharge_r2: assert property (@(posedge clk) disable iff (rst)
    !(row_vld && row_op) |=> rule_code != 4'd1);
  p_rcd_from_column_r4: assert property (@(posedge clk) disable iff (rst)
    !col_vld |=> rule_code != 4'd2 && !illegal);
endmodule

// File: tb/test_rc_spacing_chk.sv
`timescale 1ns/1ps
module test_rc_spacing_chk;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [7:0] cfg_tpp = '0, cfg_trcd = '0;
  logic [15:0] now_cyc;
  logic row_vld = 1'b0, row_op = 1'b0;
  logic [1:0] row_dev = '0, col_dev = '0, col_op = '0;
  logic [3:0] row_bank = '0, col_bank = '0;
  logic col_vld = 1'b0;
  logic viol, illegal;
  logic [3:0] rule_code;

  int cyc = 0;
  int checks = 0, errors = 0;
  int tpp = 8, trcd = 11;
  bit done = 0;
  bit m_hit[4];
  bit m_op[4];
  int m_bank[4];
  int m_ts[4];

  typedef struct {logic v; logic i; logic [3:0] c; string tag;} exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign now_cyc = cyc[15:0];

  rc_spacing_chk i_rc_spacing_chk (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_tpp(cfg_tpp), .cfg_trcd(cfg_trcd),
    .now_cyc(now_cyc), .row_vld(row_vld), .row_op(row_op), .row_dev(row_dev),
    .row_bank(row_bank), .col_vld(col_vld), .col_op(col_op), .col_dev(col_dev),
    .col_bank(col_bank), .viol(viol), .illegal(illegal), .rule_code(rule_code)
  );

  // monitor: one expected item per driven cycle, compared after the registering edge
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (viol !== e.v || illegal !== e.i || rule_code !== e.c) begin
        errors++;
        $display("FAIL %s: got viol=%0b illegal=%0b code=%0d, expected viol=%0b illegal=%0b code=%0d",
                 e.tag, viol, illegal, rule_code, e.v, e.i, e.c);
      end
    end
  end

  task automatic drive(input bit rv, input bit rop, input int rdev, input int rbank,
                       input bit cv, input int cop, input int cdev, input int cbank,
                       input string tag);
    exp_t e;
    int gap;
    e.v = 0; e.i = 0; e.c = 0; e.tag = tag;
    row_vld = rv; row_op = rop; row_dev = rdev[1:0]; row_bank = rbank[3:0];
    col_vld = cv; col_op = cop[1:0]; col_dev = cdev[1:0]; col_bank = cbank[3:0];
    // column check against the record before this cycle's row command
    if (cv && cop != 0 && m_hit[cdev]) begin
      gap = (cyc - m_ts[cdev]) & 16'hFFFF;
      if (cbank == m_bank[cdev] + 1 || cbank + 1 == m_bank[cdev]) begin
        e.i = 1; e.c = m_op[cdev] ? 4'd4 : 4'd3;
      end else if (cbank == m_bank[cdev] && !m_op[cdev] && gap < trcd) begin
        e.v = 1; e.c = 4'd2;
      end
    end
    if (!e.v && !e.i && rv && rop && m_hit[rdev] && m_op[rdev]) begin
      gap = (cyc - m_ts[rdev]) & 16'hFFFF;
      if (gap < tpp) begin e.v = 1; e.c = 4'd1; end
    end
    if (rv) begin
      m_hit[rdev] = 1; m_op[rdev] = rop; m_bank[rdev] = rbank; m_ts[rdev] = cyc;
    end
    q.push_back(e);
    @(negedge clk);
    row_vld = 0; col_vld = 0;
  endtask

  task automatic rowc(input bit op, input int dev, input int bank, input string tag);
    drive(1, op, dev, bank, 0, 0, 0, 0, tag);
  endtask

  task automatic colc(input int op, input int dev, input int bank, input string tag);
    drive(0, 0, 0, 0, 1, op, dev, bank, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_hit[k] = 0; m_op[k] = 0; m_bank[k] = 0; m_ts[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (viol !== 0 || illegal !== 0 || rule_code !== 0) begin
      errors++;
      $display("FAIL R1 reset: got %0b/%0b/%0d, expected 0/0/0", viol, illegal, rule_code);
    end
    colc(1, 3, 0, "R1 R7 access to unrecorded device");
    rowc(1, 0, 3, "R1 first precharge");
    idle(2);
    rowc(1, 0, 3, "R2 precharge same bank gap 3");
    rowc(1, 1, 3, "R3 precharge other device");
    rowc(1, 0, 4, "R2 precharge neighbour bank");
    idle(6);
    rowc(1, 0, 4, "R2 gap one below limit");
    idle(7);
    rowc(1, 0, 9, "R2 gap equal limit");
    rowc(1, 1, 3, "R3 other device after long gap");
    rowc(0, 2, 5, "R4 activate");
    colc(0, 2, 5, "R6 no-op same bank");
    idle(3);
    colc(1, 2, 5, "R4 read below tRCD");
    colc(1, 2, 9, "R6 distant bank");
    colc(2, 2, 4, "R5 write lower neighbour after activate");
    colc(3, 2, 6, "R5 retire upper neighbour after activate");
    idle(9);
    colc(2, 2, 5, "R4 write at or past tRCD");
    colc(1, 1, 5, "R6 other device non-neighbour");
    rowc(1, 3, 0, "R5 precharge bank 0");
    colc(1, 3, 1, "R5 read neighbour after precharge");
    colc(1, 3, 15, "R5 no wrap at bank edge");
    drive(1, 0, 1, 7, 1, 1, 1, 7, "R7 same-cycle row and column");
    colc(1, 1, 7, "R7 read after same-cycle activate");
    // R8 reload limits
    cfg_load = 1; cfg_tpp = 8'd3; cfg_trcd = 8'd2; tpp = 3; trcd = 2;
    @(negedge clk);
    cfg_load = 0;
    rowc(0, 2, 8, "R8 activate");
    idle(1);
    colc(1, 2, 8, "R8 read gap 2 at new tRCD");
    rowc(1, 0, 2, "R8 precharge");
    idle(1);
    rowc(1, 0, 2, "R8 precharge gap 2 below new tPP");
    idle(2);
    rowc(1, 0, 2, "R8 precharge gap 3 at new tPP");
    // R9 priority
    drive(1, 1, 0, 2, 1, 1, 2, 7, "R9 illegal beats precharge spacing");
    rowc(0, 3, 6, "R9 activate");
    drive(1, 1, 0, 2, 1, 2, 3, 6, "R9 tRCD beats precharge spacing");
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule